// File: doc/BRIEF.md
# Dual Time Alarm Flag Unit

This block watches the live calendar and time values of a real-time clock and compares them against two separately programmed alarm settings. Each alarm has its own compare value for every time field and its own enable mask, so an alarm can be set to trigger on one field alone or on any combination of fields. When an alarm starts to match, its flag is set. The flag stays set until the host clears it.

The compare runs only on the once-per-second update strobe from the timekeeping counters. A flag is set only when its alarm changes from not matching to matching. The host learns of alarms by polling the two flags in its status register. The serial front end pulses a strobe once the eighth bit of a status-register read has finished. That strobe clears both flags, so no write is needed to acknowledge an alarm.

An active-low interrupt line is also provided. Each alarm has its own enable bit for this line.

Top module: `alarm_flag_unit`

## Requirements
- R1: While reset is held and on the first cycle after it is released, both flags read 0 and `irq_n` is 1.
- R2: When `sec_tick` is high in a cycle and an alarm's enabled fields all equal the current time, that alarm's flag reads 1 from the next cycle on, provided the alarm did not match at the previous strobe.
- R3: A field whose enable bit is 0 has no effect on the compare, whatever its compare value.
- R4: An alarm whose enable mask is all zeros never sets its flag.
- R5: A flag never sets in a cycle where `sec_tick` is low, even if the alarm matches.
- R6: A flag sets only on a change from no match to match between two strobes. If the match continues across a clear, the flag is not set again.
- R7: A one-cycle pulse on `stat_rd_done` clears both flags in the next cycle.
- R8: If an alarm's set and a read-clear fall in the same cycle, that alarm's flag reads 1 afterwards. The other flag is still cleared.
- R9: The two alarms are independent. A match on one never sets the other's flag.
- R10: `irq_n` is 0 exactly while some flag `i` is 1 and `irq_en[i]` is 1. Otherwise it is 1.
- R11: Field packing, starting from the LSB of `cur_time` and of each alarm slice: seconds 6 bits, minutes 6, hours 5, day 5, month 4, year 7, weekday 3, for 36 bits in total. Enable bit 0 belongs to seconds, and so on up to bit 6 for weekday. Alarm `i` uses slice `i` of `alm_time`, `alm_fen` and `alm_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | 36 | Packed current time fields |
| sec_tick | input | 1 | One-cycle strobe on each second update |
| alm_time | input | 72 | Packed compare values, alarm 1 in the upper half |
| alm_fen | input | 14 | Per-field enable masks, 7 bits per alarm |
| irq_en | input | 2 | Interrupt enable for each alarm |
| stat_rd_done | input | 1 | One-cycle strobe at the end of a status-read byte |
| alm_flags | output | 2 | Sticky alarm flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A new alarm match and the host's status-read clear can land in the same clock cycle. In that case the set has to survive while the other flag is still cleared. The bench sets this up by clearing alarm 1's flag on a strobe cycle in which alarm 0 newly matches, with `stat_rd_done` high in that same cycle. The scoreboard then expects exactly alarm 0's flag to remain. The bench also checks the case where a match continues through a clear, expecting no flag to be set again at the next strobe.

// File: rtl/alarm_flag_pkg.sv
// Package: field widths and the packed time layout shared by the alarm unit.
// Assumes seconds sit in the least significant bits of every time word.
package alarm_flag_pkg;
    parameter int SEC_W   = 6;
    parameter int MIN_W   = 6;
    parameter int HOUR_W  = 5;
    parameter int DAY_W   = 5;
    parameter int MON_W   = 4;
    parameter int YEAR_W  = 7;
    parameter int WDAY_W  = 3;
    parameter int NFIELD  = 7;
    localparam int TIME_W = SEC_W + MIN_W + HOUR_W + DAY_W + MON_W + YEAR_W + WDAY_W;

    typedef struct packed {
        logic [WDAY_W-1:0] wday;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  sec;
    } time_t;
endpackage

// File: rtl/alarm_field_cmp.sv
// Module: masked field comparator for one alarm.
// Reports a match when every enabled field equals the current time.
// An empty mask never matches. Purely combinational.
module alarm_field_cmp
    import alarm_flag_pkg::*;
(
    input  time_t             cur,
    input  time_t             ref_t,
    input  logic [NFIELD-1:0] fen,
    output logic              match
);
    logic [NFIELD-1:0] eq;

    // Equality for each field, in the order of the enable bits
    always_comb begin
        eq[0] = (cur.sec    == ref_t.sec);
        eq[1] = (cur.minute == ref_t.minute);
        eq[2] = (cur.hour   == ref_t.hour);
        eq[3] = (cur.day    == ref_t.day);
        eq[4] = (cur.month  == ref_t.month);
        eq[5] = (cur.year   == ref_t.year);
        eq[6] = (cur.wday   == ref_t.wday);
    end

    // Match needs at least one enabled field and no enabled mismatch
    always_comb begin
        match = (|fen) && ((eq | ~fen) == {NFIELD{1'b1}});
    end
endmodule

// File: rtl/alarm_flag_cell.sv
// Module: sticky flag for one alarm with match-edge detection.
// Samples the match only on the second strobe. Sets on a new match.
// Clears on a read strobe, and a set in the same cycle wins.
module alarm_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic rd_clr,
    output logic set_pulse,
    output logic flag
);
    logic prev_match;

    // Keep the match result from the previous strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_match <= 1'b0;
        else if (tick)
            prev_match <= match;
    end

    // A new match seen on a strobe
    always_comb begin
        set_pulse = tick && match && !prev_match;
    end

    // Sticky flag, with set taking priority over the read clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_pulse)
            flag <= 1'b1;
        else if (rd_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/alarm_flag_unit.sv
// Module: top of the dual alarm flag unit.
// Instantiates a comparator and a flag cell for each alarm and
// drives the active-low interrupt from the enabled flags.
// Assumes the strobes are single-cycle and synchronous to clk.
module alarm_flag_unit
    import alarm_flag_pkg::*;
#(
    parameter int NALARM = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIME_W-1:0]          cur_time,
    input  logic                       sec_tick,
    input  logic [NALARM*TIME_W-1:0]   alm_time,
    input  logic [NALARM*NFIELD-1:0]   alm_fen,
    input  logic [NALARM-1:0]          irq_en,
    input  logic                       stat_rd_done,
    output logic [NALARM-1:0]          alm_flags,
    output logic                       irq_n
);
    logic [NALARM-1:0] match;
    logic [NALARM-1:0] set_pulse;
    time_t             cur_s;

    // View the current time as a struct
    always_comb cur_s = time_t'(cur_time);

    for (genvar i = 0; i < NALARM; i++) begin : g_alarm
        alarm_field_cmp u_cmp (
            .cur   (cur_s),
            .ref_t (time_t'(alm_time[i*TIME_W +: TIME_W])),
            .fen   (alm_fen[i*NFIELD +: NFIELD]),
            .match (match[i])
        );
        alarm_flag_cell u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (sec_tick),
            .match     (match[i]),
            .rd_clr    (stat_rd_done),
            .set_pulse (set_pulse[i]),
            .flag      (alm_flags[i])
        );
    end

    // Interrupt is low while any enabled flag is set
    always_comb begin
        irq_n = !(|(alm_flags & irq_en));
    end
endmodule

// File: rtl/alarm_flag_unit_chk.sv
// Module: assertion checker for the alarm flag unit, attached by bind.
module alarm_flag_unit_chk
    import alarm_flag_pkg::*;
#(
    parameter int NALARM = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sec_tick,
    input logic                     stat_rd_done,
    input logic [NALARM*NFIELD-1:0] alm_fen,
    input logic [NALARM-1:0]        irq_en,
    input logic [NALARM-1:0]        set_pulse,
    input logic [NALARM-1:0]        alm_flags,
    input logic                     irq_n
);
    AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_done && !sec_tick) |=> (alm_flags == '0)); // R7
    AST_IRQ_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flags == '0) |-> irq_n); // R10
    AST_IRQ_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> irq_n); // R10

    for (genvar i = 0; i < NALARM; i++) begin : g_chk
        AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alm_flags[i]) |-> $past(sec_tick)); // R5
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd_done && set_pulse[i]) |=> alm_flags[i]); // R8
        AST_EMPTY_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ((alm_fen[i*NFIELD +: NFIELD] == '0) && !alm_flags[i]) |=> !alm_flags[i]); // R4
    end
endmodule

bind alarm_flag_unit alarm_flag_unit_chk #(.NALARM(NALARM)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .stat_rd_done (stat_rd_done),
    .alm_fen      (alm_fen),
    .irq_en       (irq_en),
    .set_pulse    (set_pulse),
    .alm_flags    (alm_flags),
    .irq_n        (irq_n)
);

// File: tb/alarm_flag_unit_tb_top.sv
// Scoreboard bench: the driver pushes the expected outputs for each cycle,
// and the monitor pops them and compares them after the clock edge.
module alarm_flag_unit_tb_top;
    import alarm_flag_pkg::*;

    localparam int NA = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [TIME_W-1:0]    cur_time = '0;
    logic                 sec_tick = 1'b0;
    logic [NA*TIME_W-1:0] alm_time = '0;
    logic [NA*NFIELD-1:0] alm_fen = '0;
    logic [NA-1:0]        irq_en = '0;
    logic                 stat_rd_done = 1'b0;
    logic [NA-1:0]        alm_flags;
    logic                 irq_n;

    typedef struct {
        logic [NA-1:0] flags;
        logic          irqn;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    alarm_flag_unit #(.NALARM(NA)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_time     (cur_time),
        .sec_tick     (sec_tick),
        .alm_time     (alm_time),
        .alm_fen      (alm_fen),
        .irq_en       (irq_en),
        .stat_rd_done (stat_rd_done),
        .alm_flags    (alm_flags),
        .irq_n        (irq_n)
    );

    function automatic logic [TIME_W-1:0] mk(int s, int mi, int h, int d, int mo, int y, int w);
        time_t t;
        t.sec = SEC_W'(s); t.minute = MIN_W'(mi); t.hour = HOUR_W'(h);
        t.day = DAY_W'(d); t.month = MON_W'(mo); t.year = YEAR_W'(y); t.wday = WDAY_W'(w);
        return TIME_W'(t);
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic [TIME_W-1:0] t, input logic tk, input logic rd,
                        input logic [NA-1:0] ef, input logic ei, input string tag);
        exp_t e;
        @(negedge clk);
        cur_time = t; sec_tick = tk; stat_rd_done = rd;
        e.flags = ef; e.irqn = ei; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (alm_flags !== e.flags || irq_n !== e.irqn) begin
                    n_bad++;
                    $display("FAIL %s: flags=%b irq_n=%b expected flags=%b irq_n=%b",
                             e.tag, alm_flags, irq_n, e.flags, e.irqn);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [TIME_W-1:0] t0, ta, tb30, tb31, tw;
        t0   = mk(10, 5, 3, 1, 1, 20, 1);
        ta   = mk(45, 30, 12, 15, 6, 24, 3);
        tb30 = mk(30, 5, 3, 1, 1, 20, 1);
        tb31 = mk(31, 5, 3, 1, 1, 20, 1);
        tw   = mk(0, 1, 1, 2, 2, 2, 5);
        // alarm 0: every field set to ta; alarm 1: only seconds = 30, others arbitrary
        alm_time = {mk(30, 59, 23, 31, 12, 99, 7), ta};
        alm_fen  = {7'b0000001, 7'b1111111};
        irq_en   = 2'b11;

        // R1: reset state
        step(t0, 1'b0, 1'b0, 2'b00, 1'b1, "R1 in reset");
        step(ta, 1'b1, 1'b0, 2'b00, 1'b1, "R1 in reset with match");
        @(negedge clk); rst_n = 1'b1; cur_time = t0; sec_tick = 1'b0;
        begin exp_t e; e.flags = 2'b00; e.irqn = 1'b1; e.tag = "R1 after release"; exp_q.push_back(e); end

        step(t0, 1'b1, 1'b0, 2'b00, 1'b1, "R2 no match on strobe");
        step(ta, 1'b0, 1'b0, 2'b00, 1'b1, "R5 match without strobe");
        step(ta, 1'b1, 1'b0, 2'b01, 1'b0, "R2 R9 R10 alarm0 sets, alarm1 stays");
        step(ta, 1'b0, 1'b0, 2'b01, 1'b0, "R2 flag sticky");
        step(ta, 1'b0, 1'b1, 2'b00, 1'b1, "R7 read clears");
        step(ta, 1'b1, 1'b0, 2'b00, 1'b1, "R6 persisting match does not re-set");
        step(t0, 1'b1, 1'b0, 2'b00, 1'b1, "R6 match ends");
        step(tb30, 1'b1, 1'b0, 2'b10, 1'b0, "R3 R9 alarm1 on seconds only");
        step(tb31, 1'b1, 1'b0, 2'b10, 1'b0, "R3 alarm1 holds");
        step(ta, 1'b1, 1'b1, 2'b01, 1'b0, "R8 set wins, other cleared");

        @(negedge clk); irq_en = 2'b10; sec_tick = 1'b0; stat_rd_done = 1'b0;
        begin exp_t e; e.flags = 2'b01; e.irqn = 1'b1; e.tag = "R10 masked irq"; exp_q.push_back(e); end
        @(negedge clk); irq_en = 2'b11;
        begin exp_t e; e.flags = 2'b01; e.irqn = 1'b0; e.tag = "R10 unmasked irq"; exp_q.push_back(e); end

        // R4: empty mask on alarm 0
        @(negedge clk); alm_fen = {7'b0000001, 7'b0000000}; stat_rd_done = 1'b1;
        begin exp_t e; e.flags = 2'b00; e.irqn = 1'b1; e.tag = "R7 clear before R4"; exp_q.push_back(e); end
        step(t0, 1'b1, 1'b0, 2'b00, 1'b1, "R4 empty mask, no match");
        step(ta, 1'b1, 1'b0, 2'b00, 1'b1, "R4 empty mask never fires");

        // R11: weekday is enable bit 6 and the top field of the packing
        @(negedge clk);
        alm_fen = {7'b0000001, 7'b1000000};
        alm_time = {mk(30, 59, 23, 31, 12, 99, 7), mk(1, 2, 3, 4, 5, 6, 5)};
        sec_tick = 1'b0;
        begin exp_t e; e.flags = 2'b00; e.irqn = 1'b1; e.tag = "R11 setup"; exp_q.push_back(e); end
        step(tw, 1'b1, 1'b0, 2'b01, 1'b0, "R11 weekday-only match");
        step(tw, 1'b0, 1'b0, 2'b01, 1'b0, "R11 hold");

        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule